// File: doc/BRIEF.md
# Ring station address recognizer

This block watches the address fields of each frame that arrives on a token ring. It compares them with the station's own short (16-bit) and long (48-bit) addresses. A destination match raises the address-recognized flag (A). A source match raises the my-frame flag (M) and a strip request, which tells the repeat path to remove the frame the station sent earlier.

Short and long matching are each switched on by their own bit in a small option register. When both bits are clear, the station takes no recognition or strip action at all.

A frame-start strobe clears all three outputs. After that, each address field the parser delivers over a valid/ready stream can only set flags. So A, M and strip describe the current frame until the next strobe. The field stream never applies back-pressure: `fld_ready` is high in every cycle after reset. A field is consumed in any cycle where `fld_valid` is high and reset is released, and the upstream parser may hold `fld_valid` for as many cycles as it needs.

Top module: `ring_addr_rec`

## Requirements
- R1: The option register sits at offset 0x01 of the option write port. Bit 0 enables short matching and bit 1 enables long matching. Reset clears both bits. A write is applied at the clock edge where `opt_wr` is high and takes effect from the next cycle. Writes to any other offset leave the enables unchanged.
- R2: With short matching enabled, an accepted destination field with `fld_long`=0 whose `fld_data[15:0]` equals `my_short` sets `flag_a`.
- R3: With short matching enabled, an accepted source field with `fld_long`=0 whose `fld_data[15:0]` equals `my_short` sets both `flag_m` and `strip_req`.
- R4: With long matching enabled, an accepted destination field with `fld_long`=1 whose `fld_data[47:0]` equals `my_long` sets `flag_a`.
- R5: With long matching enabled, an accepted source field with `fld_long`=1 whose `fld_data[47:0]` equals `my_long` sets both `flag_m` and `strip_req`.
- R6: While both enable bits are 0, no field sets any of `flag_a`, `flag_m` or `strip_req`.
- R7: A `frame_start` pulse clears all three outputs on the next edge. Between frame starts, the flags are sticky: a later non-matching field does not clear them.
- R8: A short field is compared only on bits [15:0], so bits [47:16] of a short field are ignored. A field is never compared with the address of the other length: a long field is never matched against `my_short`, and a short field is never matched against `my_long`.
- R9: The outputs change on the clock edge that accepts the field, so they are visible in the following cycle. `fld_ready` is 1 in every cycle after reset.
- R10: While reset is asserted, `flag_a`, `flag_m` and `strip_req` are 0 and `fld_ready` is 0.
- R11: A field accepted in the same cycle as `frame_start` belongs to the new frame. The outputs then show only that field's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| opt_wr | input | 1 | Option register write strobe |
| opt_addr | input | 8 | Option register write offset |
| opt_wdata | input | 8 | Option register write data |
| my_short | input | 16 | Station short address |
| my_long | input | 48 | Station long address |
| frame_start | input | 1 | Strobe marking the start of a received frame |
| fld_valid | input | 1 | Address field valid |
| fld_ready | output | 1 | Address field ready (high after reset) |
| fld_is_src | input | 1 | 1 = source field, 0 = destination field |
| fld_long | input | 1 | 1 = 48-bit field, 0 = 16-bit field |
| fld_data | input | 48 | Address field; short fields use bits [15:0] |
| flag_a | output | 1 | Address-recognized flag |
| flag_m | output | 1 | My-frame flag |
| strip_req | output | 1 | Request to strip the current frame |

## Verification
The bench builds the block with its default widths: a 16-bit short address, a 48-bit long address and an 8-bit option offset. At these widths the two comparators have different sizes, so the bench can drive a short field whose upper 32 bits hold junk, and a long field whose low 16 bits equal the station short address. Both cases catch a comparator that uses the wrong slice or the wrong station address. The 8-bit offset leaves room for writes to other offsets, which must be ignored, next to the live one at 0x01.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;
  localparam int SHORT_W_DEF = 16;
  localparam int LONG_W_DEF  = 48;
  localparam int NUM_LEN     = 2;

  typedef enum logic [0:0] {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } addr_len_e;

  typedef struct packed {
    logic dst_hit;
    logic src_hit;
  } addr_hit_t;
endpackage

// File: rtl/ring_opt_reg.sv
module ring_opt_reg #(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int OFFSET = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          en_short,
  output logic          en_long
);
  localparam logic [AW-1:0] OFS = AW'(OFFSET);

  logic sel;
  assign sel = wr && (addr == OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_short <= 1'b0;
      en_long  <= 1'b0;
    end else if (sel) begin
      en_short <= wdata[0];
      en_long  <= wdata[1];
    end
  end
endmodule

// File: rtl/ring_addr_cmp.sv
module ring_addr_cmp
  import ring_addr_pkg::*;
#(
  parameter int SHORT_W = SHORT_W_DEF,
  parameter int LONG_W  = LONG_W_DEF
) (
  input  logic              en_short,
  input  logic              en_long,
  input  logic              is_long,
  input  logic              is_src,
  input  logic [LONG_W-1:0] data,
  input  logic [SHORT_W-1:0] my_short,
  input  logic [LONG_W-1:0] my_long,
  output addr_hit_t         hit
);
  logic [NUM_LEN-1:0] lane_eq;
  logic [NUM_LEN-1:0] lane_en;
  logic [NUM_LEN-1:0] lane_sel;

  // One lane per address length; each lane compares only its own width.
  for (genvar g = 0; g < NUM_LEN; g++) begin : g_lane
    if (g == int'(LEN_SHORT)) begin : g_short
      assign lane_eq[g]  = (data[SHORT_W-1:0] == my_short);
      assign lane_en[g]  = en_short;
      assign lane_sel[g] = !is_long;
    end else begin : g_long
      assign lane_eq[g]  = (data == my_long);
      assign lane_en[g]  = en_long;
      assign lane_sel[g] = is_long;
    end
  end

  logic any_match;
  assign any_match   = |(lane_eq & lane_en & lane_sel);
  assign hit.dst_hit = any_match && !is_src;
  assign hit.src_hit = any_match && is_src;
endmodule

// File: rtl/ring_flag_state.sv
module ring_flag_state
  import ring_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_start,
  input  logic      take,
  input  addr_hit_t hit,
  output logic      flag_a,
  output logic      flag_m,
  output logic      strip_req
);
  logic set_a, set_m;
  assign set_a = take && hit.dst_hit;
  assign set_m = take && hit.src_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a    <= 1'b0;
      flag_m    <= 1'b0;
      strip_req <= 1'b0;
    end else begin
      flag_a    <= (flag_a    && !frame_start) || set_a;
      flag_m    <= (flag_m    && !frame_start) || set_m;
      strip_req <= (strip_req && !frame_start) || set_m;
    end
  end
endmodule

// File: rtl/ring_addr_rec.sv
module ring_addr_rec
  import ring_addr_pkg::*;
#(
  parameter int SHORT_W    = SHORT_W_DEF,
  parameter int LONG_W     = LONG_W_DEF,
  parameter int OPT_AW     = 8,
  parameter int OPT_DW     = 8,
  parameter int OPT_OFFSET = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opt_wr,
  input  logic [OPT_AW-1:0]  opt_addr,
  input  logic [OPT_DW-1:0]  opt_wdata,
  input  logic [SHORT_W-1:0] my_short,
  input  logic [LONG_W-1:0]  my_long,
  input  logic               frame_start,
  input  logic               fld_valid,
  output logic               fld_ready,
  input  logic               fld_is_src,
  input  logic               fld_long,
  input  logic [LONG_W-1:0]  fld_data,
  output logic               flag_a,
  output logic               flag_m,
  output logic               strip_req
);
  logic      en_short, en_long;
  addr_hit_t hit;
  logic      ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign fld_ready = ready_q;

  ring_opt_reg #(
    .AW(OPT_AW), .DW(OPT_DW), .OFFSET(OPT_OFFSET)
  ) u_opt (
    .clk(clk), .rst_n(rst_n), .wr(opt_wr), .addr(opt_addr),
    .wdata(opt_wdata), .en_short(en_short), .en_long(en_long)
  );

  ring_addr_cmp #(
    .SHORT_W(SHORT_W), .LONG_W(LONG_W)
  ) u_cmp (
    .en_short(en_short), .en_long(en_long), .is_long(fld_long),
    .is_src(fld_is_src), .data(fld_data), .my_short(my_short),
    .my_long(my_long), .hit(hit)
  );

  ring_flag_state u_flags (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .take(fld_valid && fld_ready), .hit(hit),
    .flag_a(flag_a), .flag_m(flag_m), .strip_req(strip_req)
  );
endmodule

// File: rtl/ring_addr_rec_chk.sv
module ring_addr_rec_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic fld_valid,
  input logic fld_ready,
  input logic fld_is_src,
  input logic en_short,
  input logic en_long,
  input logic flag_a,
  input logic flag_m,
  input logic strip_req
);
  // R7: a start with no field clears every flag
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fld_valid) |=> (!flag_a && !flag_m && !strip_req));

  // R7: with no start and no field, the flags hold
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !fld_valid) |=> ($stable(flag_a) && $stable(flag_m) && $stable(strip_req)));

  // R2 R4: A rises only after an accepted destination field
  assert_a_from_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(fld_valid && fld_ready && !fld_is_src));

  // R3 R5: M rises only after an accepted source field
  assert_m_from_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_m) |-> $past(fld_valid && fld_ready && fld_is_src));

  // R3: strip request rises together with M
  assert_strip_with_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strip_req) |-> $rose(flag_m));

  // R6: with both enables clear, nothing rises
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_short && !en_long) |=> (!$rose(flag_a) && !$rose(flag_m) && !$rose(strip_req)));

  // R9: ready stays high once out of reset
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fld_ready);
endmodule

bind ring_addr_rec ring_addr_rec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .fld_valid(fld_valid), .fld_ready(fld_ready), .fld_is_src(fld_is_src),
  .en_short(en_short), .en_long(en_long),
  .flag_a(flag_a), .flag_m(flag_m), .strip_req(strip_req)
);

// File: tb/ring_addr_rec_tb.sv
module ring_addr_rec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_wr = 1'b0;
  logic [7:0]  opt_addr = '0;
  logic [7:0]  opt_wdata = '0;
  logic [15:0] my_short = 16'hA55A;
  logic [47:0] my_long = 48'h0123_4567_89AB;
  logic        frame_start = 1'b0;
  logic        fld_valid = 1'b0;
  logic        fld_ready;
  logic        fld_is_src = 1'b0;
  logic        fld_long = 1'b0;
  logic [47:0] fld_data = '0;
  logic        flag_a, flag_m, strip_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ring_addr_rec u_dut (
    .clk(clk), .rst_n(rst_n), .opt_wr(opt_wr), .opt_addr(opt_addr),
    .opt_wdata(opt_wdata), .my_short(my_short), .my_long(my_long),
    .frame_start(frame_start), .fld_valid(fld_valid), .fld_ready(fld_ready),
    .fld_is_src(fld_is_src), .fld_long(fld_long), .fld_data(fld_data),
    .flag_a(flag_a), .flag_m(flag_m), .strip_req(strip_req)
  );

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got a/m/s=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {flag_a, flag_m, strip_req};
  endfunction

  task automatic set_opt(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    opt_wr = 1'b1; opt_addr = a; opt_wdata = d;
    @(negedge clk);
    opt_wr = 1'b0;
  endtask

  task automatic start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic field(logic src, logic lng, logic [47:0] d, logic with_start = 1'b0);
    @(negedge clk);
    fld_valid = 1'b1; fld_is_src = src; fld_long = lng; fld_data = d;
    frame_start = with_start;
    @(negedge clk);
    fld_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 in reset", outs(), 3'b000);
    checks++;
    if (fld_ready !== 1'b0) begin errors++; $display("FAIL R10 ready=%b expected 0", fld_ready); end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (fld_ready !== 1'b1) begin errors++; $display("FAIL R9 ready=%b expected 1", fld_ready); end
    field(1'b0, 1'b0, {32'h0, my_short});
    chk("R1 enables clear after reset", outs(), 3'b000);
  endtask

  task automatic t_short();
    set_opt(8'h01, 8'h01);
    start();
    field(1'b0, 1'b0, {32'hDEAD_BEEF, my_short});
    chk("R2 R8 short dst match, upper bits junk", outs(), 3'b100);
    field(1'b1, 1'b0, {32'h0, my_short});
    chk("R3 short src match", outs(), 3'b111);
    start();
    chk("R7 cleared by start", outs(), 3'b000);
    field(1'b0, 1'b0, {32'h0, my_short ^ 16'h0001});
    chk("R2 short dst mismatch", outs(), 3'b000);
    field(1'b0, 1'b1, {32'h0, my_short});
    chk("R8 long field vs short addr", outs(), 3'b000);
    field(1'b0, 1'b1, my_long);
    chk("R4 long disabled when only short on", outs(), 3'b000);
  endtask

  task automatic t_long();
    set_opt(8'h01, 8'h02);
    start();
    field(1'b0, 1'b1, my_long);
    chk("R4 long dst match", outs(), 3'b100);
    field(1'b0, 1'b1, 48'h0);
    chk("R7 sticky after mismatch", outs(), 3'b100);
    field(1'b1, 1'b1, my_long);
    chk("R5 long src match", outs(), 3'b111);
    start();
    field(1'b1, 1'b1, my_long ^ 48'h8000_0000_0000);
    chk("R5 long src mismatch top bit", outs(), 3'b000);
    field(1'b1, 1'b0, {32'h0, my_short});
    chk("R8 short field when only long on", outs(), 3'b000);
  endtask

  task automatic t_off();
    set_opt(8'h01, 8'h00);
    start();
    field(1'b0, 1'b0, {32'h0, my_short});
    field(1'b1, 1'b0, {32'h0, my_short});
    field(1'b0, 1'b1, my_long);
    field(1'b1, 1'b1, my_long);
    chk("R6 both disabled", outs(), 3'b000);
  endtask

  task automatic t_offset();
    set_opt(8'h00, 8'h03);
    set_opt(8'h02, 8'h03);
    start();
    field(1'b1, 1'b1, my_long);
    chk("R1 other offset ignored", outs(), 3'b000);
    set_opt(8'h01, 8'h03);
    field(1'b1, 1'b1, my_long);
    chk("R1 offset 01 enables long", outs(), 3'b011);
    field(1'b0, 1'b0, {32'h0, my_short});
    chk("R2 short with both on", outs(), 3'b111);
  endtask

  task automatic t_same_cycle();
    set_opt(8'h01, 8'h03);
    start();
    field(1'b1, 1'b0, {32'h0, my_short});
    chk("R3 setup", outs(), 3'b011);
    field(1'b0, 1'b1, my_long, 1'b1);
    chk("R11 start with field", outs(), 3'b100);
    @(negedge clk);
    fld_valid = 1'b1; fld_is_src = 1'b1; fld_long = 1'b0; fld_data = {32'h0, my_short};
    #1;
    chk("R9 not visible before edge", outs(), 3'b100);
    @(negedge clk);
    fld_valid = 1'b0;
    chk("R9 visible after edge", outs(), 3'b111);
  endtask

  initial begin
    t_reset();
    t_short();
    t_long();
    t_off();
    t_offset();
    t_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule